// File: doc/BRIEF.md
# Dual-Mode FSK Tone Generator

This block produces the digital sine samples of a binary frequency-shift-keyed transmitter. A 24-bit phase accumulator advances once per sample strobe by a step chosen from eight precomputed values. The signalling family (Bell 103 or V.21), the call role (originate or answer) and the bit being sent select the step. The sample rate is 9600 Hz. The top eight accumulator bits address a folded quarter-wave sine table, which yields a signed 12-bit sample for a downstream converter.

A new tone is chosen by changing the step only. The accumulator value is never touched, so a change of bit or mode keeps the waveform phase-continuous. Pulling the enable low silences the output and sets the phase back to zero.

Top module: `fsk_tone_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sample` is 0 and the phase is 0. The first enabled strobe after reset yields the sample for phase equal to one step.
- R2: With `stdSel`=0 and `answerSel`=0, a 1 bit produces 1270 Hz and a 0 bit produces 1070 Hz.
- R3: With `stdSel`=0 and `answerSel`=1, a 1 bit produces 2225 Hz and a 0 bit produces 2025 Hz.
- R4: With `stdSel`=1 and `answerSel`=0, a 1 bit produces 980 Hz and a 0 bit produces 1180 Hz.
- R5: With `stdSel`=1 and `answerSel`=1, a 1 bit produces 1650 Hz and a 0 bit produces 1850 Hz.
- R6: The step for tone f is round(f * 2^24 / 9600). The phase wraps modulo 2^24.
- R7: The phase advances only in a cycle where `enable` and `sampleStrobe` are both high. Otherwise `sample` holds its value for as long as `enable` stays high.
- R8: A change of `txBit`, `stdSel` or `answerSel` changes only the step applied at later strobes. The accumulated phase carries over unchanged.
- R9: A cycle with `enable` low clears the phase and drives `sample` to 0 on the next edge.
- R10: On the edge after an advancing strobe, `sample` equals round(2047 * |sin(2π(p+0.5)/256)|). It is negated when p ≥ 128. Here p is the top 8 bits of the new phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Tone output enable |
| sampleStrobe | input | 1 | One-cycle pulse per output sample |
| txBit | input | 1 | Bit to send (1 = mark, 0 = space) |
| stdSel | input | 1 | 0 = Bell 103 tones, 1 = V.21 tones |
| answerSel | input | 1 | 0 = originate, 1 = answer |
| sample | output | 12 | Signed two's-complement sine sample |

## Verification
Mode and bit changes are made mid-stream, between strobes that come at irregular gaps. If a design reloaded or zeroed the phase on a switch, its waveform would jump, and every later sample would drift away from the model. The bench visits every quadrant, including the wrap past 2^24, so a wrong fold or sign shows up as a mirrored or inverted half-cycle. It also drops `enable` in the middle of a tone and then raises it again. A design that only muted the output would then resume from the old phase instead of from one step.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;  // add the step this cycle
    logic clear;    // force phase and sample to zero
  } ncoCtrl_t;

  // phase step for a tone: round(f * 2^accW / sampleHz)
  function automatic longint toneStep(input int freqHz, input int sampleHz, input int accW);
    longint num;
    num = (longint'(freqHz) << accW) + longint'(sampleHz / 2);
    return num / longint'(sampleHz);
  endfunction

  // quarter-wave magnitude at the midpoint of entry idx
  function automatic int quarterSine(input int idx, input int entries, input int amp);
    real ang;
    ang = (real'(idx) + 0.5) * (3.14159265358979323846 / 2.0) / real'(entries);
    return $rtoi($sin(ang) * real'(amp) + 0.5);
  endfunction

endpackage

// File: rtl/fsk_ctrl.sv
module fsk_ctrl
  import fsk_tone_pkg::*;
#(
  parameter int ACC_W     = 24,
  parameter int SAMPLE_HZ = 9600,
  parameter int B_ORG_MARK  = 1270,
  parameter int B_ORG_SPACE = 1070,
  parameter int B_ANS_MARK  = 2225,
  parameter int B_ANS_SPACE = 2025,
  parameter int V_ORG_MARK  = 980,
  parameter int V_ORG_SPACE = 1180,
  parameter int V_ANS_MARK  = 1650,
  parameter int V_ANS_SPACE = 1850
) (
  input  logic             enable,
  input  logic             sampleStrobe,
  input  logic             txBit,
  input  logic             stdSel,
  input  logic             answerSel,
  output ncoCtrl_t         ctl,
  output logic [ACC_W-1:0] step
);

  localparam int TONES = 8;
  localparam int FREQS [TONES] = '{
    B_ORG_SPACE, B_ORG_MARK, B_ANS_SPACE, B_ANS_MARK,
    V_ORG_SPACE, V_ORG_MARK, V_ANS_SPACE, V_ANS_MARK
  };

  logic [ACC_W-1:0] stepTab [TONES];

  for (genvar t = 0; t < TONES; t++) begin : g_step
    localparam longint STEP_L = toneStep(FREQS[t], SAMPLE_HZ, ACC_W);
    assign stepTab[t] = STEP_L[ACC_W-1:0];
  end

  logic [2:0] toneSel;
  assign toneSel = {stdSel, answerSel, txBit};

  always_comb begin
    step        = stepTab[toneSel];
    ctl.clear   = !enable;
    ctl.advance = enable && sampleStrobe;
  end

endmodule

// File: rtl/fsk_nco.sv
module fsk_nco
  import fsk_tone_pkg::*;
#(
  parameter int ACC_W   = 24,
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ncoCtrl_t           ctl,
  input  logic [ACC_W-1:0]   step,
  output logic [ACC_W-1:0]   acc,
  output logic [PHASE_W-1:0] phaseNext
);

  logic [ACC_W-1:0] accNext;

  always_comb begin
    if (ctl.clear)        accNext = '0;
    else if (ctl.advance) accNext = acc + step;
    else                  accNext = acc;
  end

  assign phaseNext = accNext[ACC_W-1 -: PHASE_W];

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= accNext;
  end

endmodule

// File: rtl/fsk_sine.sv
module fsk_sine
  import fsk_tone_pkg::*;
#(
  parameter int PHASE_W  = 8,
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ncoCtrl_t                   ctl,
  input  logic [PHASE_W-1:0]         phaseNext,
  output logic signed [SAMPLE_W-1:0] sample
);

  localparam int IDX_W   = PHASE_W - 2;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int AMP     = (1 << (SAMPLE_W - 1)) - 1;

  logic [SAMPLE_W-2:0] magTab [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_tab
    localparam int MAG = quarterSine(i, ENTRIES, AMP);
    assign magTab[i] = MAG[SAMPLE_W-2:0];
  end

  logic [1:0]                 quadrant;
  logic [IDX_W-1:0]           idx;
  logic [SAMPLE_W-2:0]        mag;
  logic signed [SAMPLE_W-1:0] folded;

  always_comb begin
    quadrant = phaseNext[PHASE_W-1 -: 2];
    idx      = phaseNext[IDX_W-1:0];
    mag      = quadrant[0] ? magTab[~idx] : magTab[idx];
    folded   = quadrant[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) sample <= '0;
    else if (ctl.advance) sample <= folded;
  end

endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
  import fsk_tone_pkg::*;
#(
  parameter int ACC_W     = 24,
  parameter int PHASE_W   = 8,
  parameter int SAMPLE_W  = 12,
  parameter int SAMPLE_HZ = 9600
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enable,
  input  logic                       sampleStrobe,
  input  logic                       txBit,
  input  logic                       stdSel,
  input  logic                       answerSel,
  output logic signed [SAMPLE_W-1:0] sample
);

  ncoCtrl_t           ctl;
  logic [ACC_W-1:0]   stepVal;
  logic [ACC_W-1:0]   accVal;
  logic [PHASE_W-1:0] phaseNext;

  fsk_ctrl #(.ACC_W(ACC_W), .SAMPLE_HZ(SAMPLE_HZ)) u_ctrl (
    .enable(enable), .sampleStrobe(sampleStrobe), .txBit(txBit),
    .stdSel(stdSel), .answerSel(answerSel), .ctl(ctl), .step(stepVal)
  );

  fsk_nco #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_nco (
    .clk(clk), .rst(rst), .ctl(ctl), .step(stepVal),
    .acc(accVal), .phaseNext(phaseNext)
  );

  fsk_sine #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_sine (
    .clk(clk), .rst(rst), .ctl(ctl), .phaseNext(phaseNext), .sample(sample)
  );

endmodule

// File: rtl/fsk_tone_gen_chk.sv
module fsk_tone_gen_chk #(
  parameter int ACC_W    = 24,
  parameter int SAMPLE_W = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       enable,
  input logic                       sampleStrobe,
  input logic signed [SAMPLE_W-1:0] sample,
  input logic [ACC_W-1:0]           accVal,
  input logic [ACC_W-1:0]           stepVal
);

  // R9
  disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (sample == '0));

  // R9
  phase_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (accVal == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !sampleStrobe) |=> ($stable(sample) && $stable(accVal)));

  // R8
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && sampleStrobe) |=> (accVal == ACC_W'($past(accVal) + $past(stepVal))));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    sample != {1'b1, {(SAMPLE_W-1){1'b0}}});

endmodule

bind fsk_tone_gen fsk_tone_gen_chk #(.ACC_W(ACC_W), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .sampleStrobe(sampleStrobe),
  .sample(sample), .accVal(accVal), .stepVal(stepVal)
);

// File: tb/fsk_tone_gen_test.sv
`timescale 1ns/1ps
module fsk_tone_gen_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, sampleStrobe = 1'b0, txBit = 1'b0, stdSel = 1'b0, answerSel = 1'b0;
  logic signed [11:0] sample;

  always #10 clk = ~clk;  // 50 MHz

  fsk_tone_gen uut (
    .clk(clk), .rst(rst), .enable(enable), .sampleStrobe(sampleStrobe),
    .txBit(txBit), .stdSel(stdSel), .answerSel(answerSel), .sample(sample)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // behavioural reference
  longint modelAcc = 0;
  int     modelSample = 0;

  function automatic int freqOf(input logic s, input logic a, input logic b);
    if (!s && !a) return b ? 1270 : 1070;
    if (!s &&  a) return b ? 2225 : 2025;
    if ( s && !a) return b ? 980  : 1180;
    return b ? 1650 : 1850;
  endfunction

  function automatic longint stepOf(input int f);
    return longint'($rtoi(real'(f) * 16777216.0 / 9600.0 + 0.5));
  endfunction

  function automatic int sineOf(input longint acc);
    int  p;
    real ang;
    int  mag;
    p   = int'(acc >> 16);
    ang = (real'(p) + 0.5) * 2.0 * 3.14159265358979323846 / 256.0;
    mag = $rtoi(2047.0 * (($sin(ang) < 0.0) ? -$sin(ang) : $sin(ang)) + 0.5);
    return (p >= 128) ? -mag : mag;
  endfunction

  always @(posedge clk) begin
    if (rst || !enable) begin
      modelAcc    = 0;
      modelSample = 0;
    end else if (sampleStrobe) begin
      modelAcc    = (modelAcc + stepOf(freqOf(stdSel, answerSel, txBit))) % 64'd16777216;
      modelSample = sineOf(modelAcc);
    end
  end

  task automatic compare();
    checks++;
    if (int'(sample) != modelSample) begin
      errors++;
      $display("FAIL %s: sample actual %0d expected %0d at %0t", tag, sample, modelSample, $time);
    end
  endtask

  // one clock: check at the falling edge, then leave new inputs for the next rising edge
  task automatic tick(input logic strobe);
    @(negedge clk);
    compare();
    sampleStrobe = strobe;
  endtask

  // run n strobes with irregular gaps, optionally flipping the bit
  task automatic runTone(input int n, input bit toggle);
    for (int k = 0; k < n; k++) begin
      if (toggle && (k % 7 == 3)) txBit = ~txBit;
      tick(1'b1);
      for (int g = 0; g < (k % 3); g++) tick(1'b0);
    end
    tick(1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) tick(1'b0);
    rst = 1'b0;
    enable = 1'b1;
    tick(1'b0);
    tick(1'b1);  // first strobe: phase = one step
    tick(1'b0);

    // R2 R6 R10: Bell 103 originate, mark then space, long enough to wrap
    tag = "R2"; stdSel = 1'b0; answerSel = 1'b0; txBit = 1'b1;
    runTone(60, 1'b0);
    txBit = 1'b0;
    runTone(60, 1'b0);

    // R3: Bell 103 answer with mid-stream bit changes (R8)
    tag = "R3"; answerSel = 1'b1;
    runTone(80, 1'b1);

    // R4: V.21 originate
    tag = "R4"; stdSel = 1'b1; answerSel = 1'b0; txBit = 1'b1;
    runTone(70, 1'b1);

    // R5: V.21 answer
    tag = "R5"; answerSel = 1'b1; txBit = 1'b0;
    runTone(70, 1'b1);

    // R8: switch family and role between strobes, phase must carry over
    tag = "R8";
    for (int m = 0; m < 16; m++) begin
      stdSel = m[0]; answerSel = m[1]; txBit = m[2];
      tick(1'b1);
      tick(1'b0);
    end

    // R7: inputs change with no strobe, output must hold
    tag = "R7";
    for (int m = 0; m < 12; m++) begin
      txBit = ~txBit; stdSel = m[1];
      tick(1'b0);
    end

    // R9: disable mid-tone, then restart from phase zero
    tag = "R9";
    tick(1'b1);
    enable = 1'b0;
    tick(1'b1);  // strobe while disabled is ignored
    tick(1'b1);
    tick(1'b0);
    enable = 1'b1;
    tick(1'b0);
    tick(1'b1);
    tick(1'b0);

    // R6: long mark/space run across many wraps
    tag = "R6"; stdSel = 1'b0; answerSel = 1'b1;
    runTone(300, 1'b1);

    // R1: reset in the middle of a tone
    tag = "R1";
    rst = 1'b1;
    tick(1'b1);
    tick(1'b0);
    rst = 1'b0;
    tick(1'b0);
    tick(1'b1);
    tick(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule